// File: doc/BRIEF.md
# FIFO Interrupt Threshold Generator

This block raises the receive and transmit FIFO service requests for one UART channel whose FIFOs hold 64 characters each. The receive request compares the receive fill count against a threshold. The transmit request compares the free space in the transmit FIFO against a threshold of its own. The two directions are configured independently.

Each threshold has two possible sources. The first is a 2-bit level code held in the FIFO control register. The second is a 4-bit nibble in a programmable level byte. A nonzero nibble overrides the code and gives a threshold of four times its value. While the FIFOs are disabled, both thresholds fall back to one character. Both request flags are registered, so the FIFO count logic and the interrupt priority logic see clean signals one clock after any input change.

The block has no data-flow interface. All of its pins are plain control and status levels.

Top module: `ftl_trigger_gen`

## Requirements
- R1: While `rst_n` is low, both `rx_trigger` and `tx_trigger` are low.
- R2: With `fifo_en` low, both thresholds are one character, whatever the level codes and `prog_levels` hold. `rx_trigger` follows `rx_count >= 1` and `tx_trigger` follows `64 - tx_count >= 1`.
- R3: With `fifo_en` high and `prog_levels[7:4]` zero, `rx_level_code` values 0, 1, 2 and 3 select receive thresholds of 8, 16, 56 and 60 characters.
- R4: With `fifo_en` high and `prog_levels[3:0]` zero, `tx_level_code` values 0, 1, 2 and 3 select transmit thresholds of 8, 16, 32 and 56 free spaces.
- R5: With `fifo_en` high and `prog_levels[7:4]` = n nonzero, the receive threshold is 4*n (4 to 60) and `rx_level_code` has no effect.
- R6: With `fifo_en` high and `prog_levels[3:0]` = n nonzero, the transmit threshold is 4*n (4 to 60) and `tx_level_code` has no effect.
- R7: `rx_trigger` is high exactly when `rx_count` is at or above the receive threshold. Counts above 64 compare as given.
- R8: Transmit free space is 64 minus `tx_count`, or zero when `tx_count` is 64 or more. `tx_trigger` is high exactly when the free space is at or above the transmit threshold.
- R9: Each flag reflects the inputs sampled at the previous rising clock edge. A change in count or configuration appears on the flag one clock later, not in the same cycle.
- R10: Receive settings and `rx_count` have no effect on `tx_trigger`. Transmit settings and `tx_count` have no effect on `rx_trigger`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO enable; when low, both thresholds are one character |
| rx_level_code | input | 2 | Coded receive threshold selection |
| tx_level_code | input | 2 | Coded transmit threshold selection |
| prog_levels | input | 8 | Programmable levels: [7:4] receive nibble, [3:0] transmit nibble |
| rx_count | input | 7 | Characters held in the receive FIFO |
| tx_count | input | 7 | Characters held in the transmit FIFO |
| rx_trigger | output | 1 | Receive service request, registered |
| tx_trigger | output | 1 | Transmit service request, registered |

## Verification
The hardest cases to reach from the ports are the exact threshold edges: the count one below the threshold and the count equal to it, for every combination of code and nibble. The override must also be shown to mask the code in both directions. The bench sweeps every enable, code and nibble value against every count from 0 to 65, so each edge is visited. In the same sweep the receive and transmit settings run in opposite orders, which makes the independence requirement fail visibly if the two paths are crossed.

// File: rtl/ftl_pkg.sv
package ftl_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int LVL_W      = CNT_W;
  localparam int NIB_W      = 4;
  localparam int NIB_SCALE  = 4;
  localparam int CODE_W     = 2;
  localparam int N_DIR      = 2;

  typedef enum logic { DIR_RX = 1'b0, DIR_TX = 1'b1 } dir_e;

  // Coded threshold table per direction
  function automatic logic [LVL_W-1:0] coded_level(input dir_e dir, input logic [CODE_W-1:0] code);
    logic [LVL_W-1:0] lvl;
    if (dir == DIR_RX) begin
      case (code)
        2'd0:    lvl = LVL_W'(8);
        2'd1:    lvl = LVL_W'(16);
        2'd2:    lvl = LVL_W'(56);
        default: lvl = LVL_W'(60);
      endcase
    end else begin
      case (code)
        2'd0:    lvl = LVL_W'(8);
        2'd1:    lvl = LVL_W'(16);
        2'd2:    lvl = LVL_W'(32);
        default: lvl = LVL_W'(56);
      endcase
    end
    return lvl;
  endfunction
endpackage

// File: rtl/ftl_level_sel.sv
module ftl_level_sel
  import ftl_pkg::*;
#(
  parameter dir_e DIR = DIR_RX
) (
  input  logic              fifo_en,
  input  logic [CODE_W-1:0] code,
  input  logic [NIB_W-1:0]  nib,
  output logic [LVL_W-1:0]  level
);
  localparam logic [LVL_W-1:0] MIN_LEVEL = LVL_W'(1);

  logic [LVL_W-1:0] prog_level;
  assign prog_level = LVL_W'(nib) * LVL_W'(NIB_SCALE);

  always_comb begin
    if (!fifo_en)          level = MIN_LEVEL;
    else if (nib != '0)    level = prog_level;
    else                   level = coded_level(DIR, code);
  end
endmodule

// File: rtl/ftl_flag_reg.sv
module ftl_flag_reg
  import ftl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] metric,
  input  logic [LVL_W-1:0] level,
  output logic             flag
);
  logic hit;
  assign hit = (metric >= level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= hit;
  end
endmodule

// File: rtl/ftl_trigger_gen.sv
module ftl_trigger_gen
  import ftl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [CODE_W-1:0] rx_level_code,
  input  logic [CODE_W-1:0] tx_level_code,
  input  logic [7:0]        prog_levels,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  output logic              rx_trigger,
  output logic              tx_trigger
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] tx_free;
  assign tx_free = (tx_count >= DEPTH_C) ? '0 : (DEPTH_C - tx_count);

  logic [CODE_W-1:0] code_v   [N_DIR];
  logic [NIB_W-1:0]  nib_v    [N_DIR];
  logic [CNT_W-1:0]  metric_v [N_DIR];
  logic              flag_v   [N_DIR];

  assign code_v[0]   = rx_level_code;
  assign code_v[1]   = tx_level_code;
  assign nib_v[0]    = prog_levels[7:4];
  assign nib_v[1]    = prog_levels[3:0];
  assign metric_v[0] = rx_count;
  assign metric_v[1] = tx_free;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    localparam dir_e DIR = (d == 0) ? DIR_RX : DIR_TX;
    logic [LVL_W-1:0] level;

    ftl_level_sel #(.DIR(DIR)) u_sel (
      .fifo_en (fifo_en),
      .code    (code_v[d]),
      .nib     (nib_v[d]),
      .level   (level)
    );

    ftl_flag_reg u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .metric (metric_v[d]),
      .level  (level),
      .flag   (flag_v[d])
    );
  end

  assign rx_trigger = flag_v[0];
  assign tx_trigger = flag_v[1];
endmodule

// File: rtl/ftl_trigger_gen_chk.sv
module ftl_trigger_gen_chk
  import ftl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_en,
  input logic [CODE_W-1:0] rx_level_code,
  input logic [CODE_W-1:0] tx_level_code,
  input logic [7:0]        prog_levels,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  tx_count,
  input logic              rx_trigger,
  input logic              tx_trigger
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1: both flags stay low while reset is held
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_low_r1: assert (!rx_trigger && !tx_trigger);
    end
  end

  // R2: disabled FIFOs give a threshold of one character
  p_disabled_rx_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(fifo_en) |-> (rx_trigger == ($past(rx_count) != '0)));
  p_disabled_tx_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(fifo_en) |-> (tx_trigger == ($past(tx_count) < CNT_W'(FIFO_DEPTH))));

  // R3: top coded receive level is 60
  p_code_rx_top_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(fifo_en && prog_levels[7:4] == 4'd0 && rx_level_code == 2'd3)
      |-> (rx_trigger == ($past(rx_count) >= CNT_W'(60))));

  // R5: nonzero receive nibble sets 4*n
  p_prog_rx_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(fifo_en && prog_levels[7:4] != 4'd0)
      |-> (rx_trigger == ($past(rx_count) >= {1'b0, $past(prog_levels[7:4]), 2'b00})));

  // R6: nonzero transmit nibble sets 4*n free spaces
  p_prog_tx_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(fifo_en && prog_levels[3:0] != 4'd0 && tx_count <= CNT_W'(FIFO_DEPTH))
      |-> (tx_trigger == ((CNT_W'(FIFO_DEPTH) - $past(tx_count)) >= {1'b0, $past(prog_levels[3:0]), 2'b00})));

  // R8: a full transmit FIFO never requests service
  p_full_tx_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(tx_count) >= CNT_W'(FIFO_DEPTH)) |-> !tx_trigger);

  // R7: an empty receive FIFO never requests service
  p_empty_rx_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(rx_count) == '0) |-> !rx_trigger);
endmodule

bind ftl_trigger_gen ftl_trigger_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_en       (fifo_en),
  .rx_level_code (rx_level_code),
  .tx_level_code (tx_level_code),
  .prog_levels   (prog_levels),
  .rx_count      (rx_count),
  .tx_count      (tx_count),
  .rx_trigger    (rx_trigger),
  .tx_trigger    (tx_trigger)
);

// File: tb/ftl_trigger_gen_bench.sv
module ftl_trigger_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0;
  logic [1:0] rx_level_code = '0;
  logic [1:0] tx_level_code = '0;
  logic [7:0] prog_levels = '0;
  logic [6:0] rx_count = '0;
  logic [6:0] tx_count = '0;
  logic       rx_trigger;
  logic       tx_trigger;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  ftl_trigger_gen u_ftl_trigger_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .rx_level_code (rx_level_code),
    .tx_level_code (tx_level_code),
    .prog_levels   (prog_levels),
    .rx_count      (rx_count),
    .tx_count      (tx_count),
    .rx_trigger    (rx_trigger),
    .tx_trigger    (tx_trigger)
  );

  function automatic int rx_thr(bit en, int code, int nib);
    int tbl[4] = '{8, 16, 56, 60};
    if (!en) return 1;
    if (nib != 0) return 4 * nib;
    return tbl[code];
  endfunction

  function automatic int tx_thr(bit en, int code, int nib);
    int tbl[4] = '{8, 16, 32, 56};
    if (!en) return 1;
    if (nib != 0) return 4 * nib;
    return tbl[code];
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (en=%0b rxc=%0d txc=%0d prog=%h rxn=%0d txn=%0d)",
               req, act, exp, fifo_en, rx_level_code, tx_level_code, prog_levels, rx_count, tx_count);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rx", rx_trigger, 1'b0);
    check("R1 tx", tx_trigger, 1'b0);
    rst_n = 1'b1;

    // Sweep: RX and TX settings run in opposite orders (R10)
    for (int en = 0; en < 2; en++) begin
      for (int c = 0; c < 4; c++) begin
        for (int nib = 0; nib < 16; nib++) begin
          for (int k = 0; k <= 65; k++) begin
            int tn;
            int tk;
            int free;
            string rtag;
            string ttag;
            tn = 15 - nib;
            tk = 65 - k;
            @(negedge clk);
            fifo_en       = en[0];
            rx_level_code = c[1:0];
            tx_level_code = 2'(3 - c);
            prog_levels   = {nib[3:0], tn[3:0]};
            rx_count      = k[6:0];
            tx_count      = tk[6:0];
            @(negedge clk);
            free = (tk >= 64) ? 0 : 64 - tk;
            rtag = (en == 0) ? "R7 R2" : (nib != 0) ? "R7 R5" : "R7 R3";
            ttag = (en == 0) ? "R8 R2" : (tn != 0) ? "R8 R6" : "R8 R4";
            check(rtag, rx_trigger, k >= rx_thr(en[0], c, nib));
            check(ttag, tx_trigger, free >= tx_thr(en[0], 3 - c, tn));
          end
        end
      end
    end

    // R9: one-clock latency
    @(negedge clk);
    fifo_en = 1'b1; prog_levels = 8'h00; rx_level_code = 2'd0; tx_level_code = 2'd0;
    rx_count = 7'd10; tx_count = 7'd0;
    @(negedge clk);
    check("R9 rx settled", rx_trigger, 1'b1);
    rx_count = 7'd2;
    tx_count = 7'd60;
    #1;
    check("R9 rx holds before edge", rx_trigger, 1'b1);
    check("R9 tx holds before edge", tx_trigger, 1'b1);
    @(negedge clk);
    check("R9 rx after edge", rx_trigger, 1'b0);
    check("R9 tx after edge", tx_trigger, 1'b0);

    // R10: receive-side changes leave tx_trigger alone
    tx_count = 7'd40;
    @(negedge clk);
    check("R10 tx base", tx_trigger, 1'b1);
    prog_levels = 8'hF0; rx_level_code = 2'd3; rx_count = 7'd64;
    @(negedge clk);
    check("R10 tx unchanged", tx_trigger, 1'b1);
    check("R10 rx moved", rx_trigger, 1'b1);

    // R1: reset in mid-run clears flags
    rst_n = 1'b0;
    #1;
    check("R1 rx async", rx_trigger, 1'b0);
    check("R1 tx async", tx_trigger, 1'b0);
    done = 1;
    finish_run();
  end
endmodule